// File: doc/BRIEF.md
# Remote Transfer Progress Counter Bank

This block keeps one countdown per in-flight remote transfer. When a new remote read request or remote write starts, the requester offers the transfer size in bytes. The block returns a free transaction id in the same cycle and binds that id to a counter. The counter is loaded with the number of short responses that the transfer splits into. This number is the byte size divided by the largest response payload, rounded up.

Each time the response machinery finishes one short response, it reports the id on the done port. The counter for that id then steps down by one. When a counter reaches zero, the block emits a one-cycle completion pulse that carries the id, and the id returns to the free pool at once. Software can read any counter at any time through a combinational read port, for example while debugging a stalled transfer. A done report for an id that is not in use is dropped and latches an error flag.

Top module: `rdma_xfer_tracker`

## Requirements
- R1: After reset no id is in use: every counter reads 0 with its in-use flag low, alloc_busy, cmpl_valid and err_sticky are low.
- R2: When alloc_valid is high, alloc_size is nonzero and some id is free, alloc_ok is high in that cycle and alloc_id is the lowest-numbered free id. From the next cycle that id is in use and its counter reads ceil(alloc_size / 2^PAY_LOG2), which is 64-byte responses by default.
- R3: A done report (done_valid with done_id) for an in-use id whose counter is above one lowers that counter by exactly one in the next cycle, and touches no other counter.
- R4: A done report that takes a counter from one to zero raises cmpl_valid for exactly the next cycle with cmpl_id equal to that id. The id reads as not in use from that cycle and is offered again by the next allocation.
- R5: alloc_busy is high exactly when every id is in use. In that case an allocation gets alloc_ok low, and no counter changes.
- R6: An allocation with alloc_size equal to 0 gets alloc_ok low and claims no id.
- R7: A done report for an id that is not in use changes no counter, produces no completion, and sets err_sticky, which then stays high until reset.
- R8: When an allocation claims the same id that a done report names in the same cycle, the allocation wins. The counter is loaded with the full response count, no completion is produced, and the done report counts as naming an unused id.
- R9: rd_cnt and rd_active show, without delay, the counter value and in-use flag of the id selected by rd_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to start tracking a transfer |
| alloc_size | input | SIZE_W | Transfer size in bytes |
| alloc_ok | output | 1 | Allocation accepted this cycle |
| alloc_id | output | ID_W | Id granted (lowest free) |
| alloc_busy | output | 1 | All ids are in use |
| done_valid | input | 1 | One short response finished |
| done_id | input | ID_W | Id of the finished response |
| cmpl_valid | output | 1 | One-cycle transfer completion pulse |
| cmpl_id | output | ID_W | Id of the completed transfer |
| err_sticky | output | 1 | A done report named an unused id |
| rd_addr | input | ID_W | Counter selected for software read |
| rd_cnt | output | CNT_W | Value of the selected counter |
| rd_active | output | 1 | Selected id is in use |

## Verification
The hardest case to reach is the cycle in which an allocation and a done report land on the same id. The bench first drains a transfer so that its id becomes the lowest free one. It then issues the next allocation together with a done report for that id. After that it checks that the full count was loaded and that no completion appeared. Filling the bank to the busy state takes a loop of allocations. The loop is driven from the bench's own model of which ids are free, and the bank is then drained id by id. A queue of expected completions follows the order of the pulses.

// File: rtl/rxt_pkg.sv
package rxt_pkg;
  // Number of responses for a byte count, payload of 2**pay_log2 bytes.
  function automatic logic [31:0] resp_count(input logic [31:0] bytes,
                                             input int unsigned pay_log2);
    logic [31:0] round_up;
    round_up = (32'd1 << pay_log2) - 32'd1;
    return (bytes + round_up) >> pay_log2;
  endfunction
endpackage

// File: rtl/rxt_slot.sv
module rxt_slot #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             active,
  output logic             retire
);
  logic [CNT_W-1:0] cnt_nxt;
  logic             cnt_en;

  always_comb begin
    cnt_nxt = cnt;
    cnt_en  = 1'b0;
    if (load) begin
      cnt_nxt = load_val;
      cnt_en  = 1'b1;
    end else if (dec && (cnt != '0)) begin
      cnt_nxt = cnt - 1'b1;
      cnt_en  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_nxt;
  end

  assign active = (cnt != '0);
  assign retire = dec && !load && (cnt == {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/rxt_pick.sv
module rxt_pick #(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = 3
) (
  input  logic [NUM_IDS-1:0] used,
  output logic               any_free,
  output logic [ID_W-1:0]    pick_id
);
  always_comb begin
    any_free = 1'b0;
    pick_id  = '0;
    for (int i = NUM_IDS - 1; i >= 0; i--) begin
      if (!used[i]) begin
        any_free = 1'b1;
        pick_id  = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/rdma_xfer_tracker.sv
module rdma_xfer_tracker #(
  parameter int NUM_IDS  = 8,
  parameter int SIZE_W   = 16,
  parameter int PAY_LOG2 = 6,
  localparam int ID_W    = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1,
  localparam int CNT_W   = SIZE_W - PAY_LOG2 + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  input  logic [SIZE_W-1:0] alloc_size,
  output logic              alloc_ok,
  output logic [ID_W-1:0]   alloc_id,
  output logic              alloc_busy,
  input  logic              done_valid,
  input  logic [ID_W-1:0]   done_id,
  output logic              cmpl_valid,
  output logic [ID_W-1:0]   cmpl_id,
  output logic              err_sticky,
  input  logic [ID_W-1:0]   rd_addr,
  output logic [CNT_W-1:0]  rd_cnt,
  output logic              rd_active
);
  logic [NUM_IDS-1:0] active_vec;
  logic [NUM_IDS-1:0] retire_vec;
  logic [NUM_IDS-1:0] hit_vec;
  logic [CNT_W-1:0]   cnt_arr [NUM_IDS];
  logic               any_free;
  logic [ID_W-1:0]    pick_id;
  logic [31:0]        need_full;
  logic [CNT_W-1:0]   need_cnt;
  logic               bad_done;
  logic               cmpl_valid_nxt;
  logic [ID_W-1:0]    cmpl_id_nxt;
  logic               err_nxt;
  logic               err_en;

  rxt_pick #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_pick (
    .used     (active_vec),
    .any_free (any_free),
    .pick_id  (pick_id)
  );

  assign need_full  = rxt_pkg::resp_count(32'(alloc_size), PAY_LOG2);
  assign need_cnt   = need_full[CNT_W-1:0];
  assign alloc_busy = !any_free;
  assign alloc_ok   = alloc_valid && any_free && (alloc_size != '0);
  assign alloc_id   = pick_id;

  for (genvar g = 0; g < NUM_IDS; g++) begin : g_slot
    logic load_g;
    assign hit_vec[g] = done_valid && (done_id == ID_W'(g));
    assign load_g     = alloc_ok && (pick_id == ID_W'(g));
    rxt_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_g),
      .load_val (need_cnt),
      .dec      (hit_vec[g] && active_vec[g]),
      .cnt      (cnt_arr[g]),
      .active   (active_vec[g]),
      .retire   (retire_vec[g])
    );
  end

  assign bad_done = done_valid && ((hit_vec & active_vec) == '0);

  always_comb begin
    cmpl_valid_nxt = |retire_vec;
    cmpl_id_nxt    = done_id;
    err_nxt        = 1'b1;
    err_en         = bad_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmpl_valid <= 1'b0;
      cmpl_id    <= '0;
    end else begin
      cmpl_valid <= cmpl_valid_nxt;
      cmpl_id    <= cmpl_id_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_sticky <= 1'b0;
    else if (err_en) err_sticky <= err_nxt;
  end

  assign rd_cnt    = cnt_arr[rd_addr];
  assign rd_active = active_vec[rd_addr];
endmodule

// File: rtl/rxt_tracker_chk.sv
module rxt_tracker_chk #(
  parameter int NUM_IDS = 8,
  parameter int ID_W    = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_ok,
  input logic [ID_W-1:0]    alloc_id,
  input logic               alloc_busy,
  input logic               done_valid,
  input logic [ID_W-1:0]    done_id,
  input logic               cmpl_valid,
  input logic [ID_W-1:0]    cmpl_id,
  input logic               err_sticky,
  input logic [NUM_IDS-1:0] active_vec
);
  assert_alloc_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_ok |=> active_vec[$past(alloc_id)]);

  assert_cmpl_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |-> ($past(done_valid) && ($past(done_id) == cmpl_id)));

  assert_cmpl_freed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmpl_valid |-> !active_vec[cmpl_id]);

  assert_busy_refuse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_busy |-> !alloc_ok);

  assert_err_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_sticky |=> err_sticky);
endmodule

bind rdma_xfer_tracker rxt_tracker_chk #(.NUM_IDS(NUM_IDS), .ID_W(ID_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .alloc_ok   (alloc_ok),
  .alloc_id   (alloc_id),
  .alloc_busy (alloc_busy),
  .done_valid (done_valid),
  .done_id    (done_id),
  .cmpl_valid (cmpl_valid),
  .cmpl_id    (cmpl_id),
  .err_sticky (err_sticky),
  .active_vec (active_vec)
);

// File: tb/rdma_xfer_tracker_bench.sv
module rdma_xfer_tracker_bench;
  localparam int NUM_IDS = 8;
  localparam int ID_W    = 3;
  localparam int CNT_W   = 11;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             alloc_valid = 1'b0;
  logic [15:0]      alloc_size = '0;
  logic             alloc_ok;
  logic [ID_W-1:0]  alloc_id;
  logic             alloc_busy;
  logic             done_valid = 1'b0;
  logic [ID_W-1:0]  done_id = '0;
  logic             cmpl_valid;
  logic [ID_W-1:0]  cmpl_id;
  logic             err_sticky;
  logic [ID_W-1:0]  rd_addr = '0;
  logic [CNT_W-1:0] rd_cnt;
  logic             rd_active;

  int checks = 0;
  int failures = 0;
  int model [NUM_IDS];
  bit exp_err = 1'b0;
  int exp_q [$];
  bit finished = 1'b0;

  always #10 clk = ~clk;

  rdma_xfer_tracker u_rdma_xfer_tracker (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_size(alloc_size),
    .alloc_ok(alloc_ok), .alloc_id(alloc_id), .alloc_busy(alloc_busy),
    .done_valid(done_valid), .done_id(done_id),
    .cmpl_valid(cmpl_valid), .cmpl_id(cmpl_id), .err_sticky(err_sticky),
    .rd_addr(rd_addr), .rd_cnt(rd_cnt), .rd_active(rd_active)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rd(input int id, input string tag);
    rd_addr = id[ID_W-1:0];
    #1;
    chk(int'(rd_cnt) == model[id], tag, int'(rd_cnt), model[id]);
    chk(rd_active == (model[id] != 0), tag, int'(rd_active), int'(model[id] != 0));
  endtask

  task automatic cyc(input bit av, input int sz, input bit dv, input int did,
                     input string tag);
    int exp_id;
    bit exp_ok;
    exp_id = -1;
    @(negedge clk);
    alloc_valid = av;
    alloc_size  = sz[15:0];
    done_valid  = dv;
    done_id     = did[ID_W-1:0];
    for (int i = NUM_IDS - 1; i >= 0; i--) if (model[i] == 0) exp_id = i;
    exp_ok = av && (sz != 0) && (exp_id >= 0);
    #1;
    chk(alloc_busy == (exp_id < 0), {tag, " R5 busy"}, int'(alloc_busy), int'(exp_id < 0));
    if (av) chk(alloc_ok == exp_ok, {tag, " alloc_ok"}, int'(alloc_ok), int'(exp_ok));
    if (exp_ok) chk(int'(alloc_id) == exp_id, {tag, " R2 id"}, int'(alloc_id), exp_id);
    if (dv) begin
      if (model[did] != 0) begin
        model[did]--;
        if (model[did] == 0) exp_q.push_back(did);
      end else begin
        exp_err = 1'b1;
      end
    end
    if (exp_ok) model[exp_id] = (sz + 63) / 64;
    @(posedge clk);
    #1;
    alloc_valid = 1'b0;
    done_valid  = 1'b0;
    chk(err_sticky == exp_err, {tag, " R7 err"}, int'(err_sticky), int'(exp_err));
  endtask

  // Monitor: every completion pulse must match the head of the queue (R4).
  always @(posedge clk) begin
    #2;
    if (rst_n && cmpl_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R4 unexpected completion", int'(cmpl_id), -1);
      end else begin
        int e;
        e = exp_q.pop_front();
        chk(int'(cmpl_id) == e, "R4 completion id", int'(cmpl_id), e);
      end
    end
  end

  task automatic finish_run();
    chk(exp_q.size() == 0, "R4 missing completions", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < NUM_IDS; i++) model[i] = 0;
    #35;
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk(err_sticky == 1'b0, "R1 err", int'(err_sticky), 0);
    chk(cmpl_valid == 1'b0, "R1 cmpl", int'(cmpl_valid), 0);
    chk(alloc_busy == 1'b0, "R1 busy", int'(alloc_busy), 0);
    for (int i = 0; i < NUM_IDS; i++) chk_rd(i, "R1 reset counter");

    // R6: zero-size refused
    cyc(1, 0, 0, 0, "R6 zero size");
    chk_rd(0, "R6 nothing claimed");

    // R2 and R9: allocations with several sizes
    cyc(1, 130, 0, 0, "R2 size130");
    cyc(1, 64, 0, 0, "R2 size64");
    cyc(1, 1, 0, 0, "R2 size1");
    cyc(1, 65535, 0, 0, "R2 size65535");
    for (int i = 0; i < 5; i++) chk_rd(i, "R9 read after alloc");

    // R4: single-response transfer completes, id reused lowest-first
    cyc(0, 0, 1, 1, "R4 done id1");
    chk_rd(1, "R4 id1 freed");
    cyc(1, 200, 0, 0, "R2 reuse id1");
    chk_rd(1, "R2 id1 count4");

    // R3: step id0 down to zero
    cyc(0, 0, 1, 0, "R3 dec id0");
    chk_rd(0, "R3 id0 after 1");
    chk_rd(1, "R3 id1 untouched");
    cyc(0, 0, 1, 0, "R3 dec id0");
    chk_rd(0, "R3 id0 after 2");
    cyc(0, 0, 1, 0, "R4 last id0");
    chk_rd(0, "R4 id0 freed");

    // R7: done for unused id
    cyc(0, 0, 1, 0, "R7 stray done");
    chk_rd(0, "R7 id0 unchanged");

    // R8: allocation and done on the same id in one cycle
    cyc(1, 100, 1, 0, "R8 same cycle");
    chk_rd(0, "R8 full count");

    // R5: fill the bank, then one more
    for (int k = 0; k < NUM_IDS; k++) begin
      bit anyf;
      anyf = 1'b0;
      for (int i = 0; i < NUM_IDS; i++) if (model[i] == 0) anyf = 1'b1;
      if (anyf) cyc(1, 640, 0, 0, "R5 fill");
    end
    cyc(1, 640, 0, 0, "R5 full refuse");
    for (int i = 0; i < NUM_IDS; i++) chk_rd(i, "R5 state unchanged");

    // Drain everything; completions checked through the queue
    for (int i = 0; i < NUM_IDS; i++) begin
      while (model[i] != 0) cyc(0, 0, 1, i, "R3 drain");
    end
    @(negedge clk);
    @(negedge clk);
    for (int i = 0; i < NUM_IDS; i++) chk_rd(i, "R4 all freed");

    finished = 1'b1;
    finish_run();
  end
endmodule